// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a word-wide register whose contents can be kept, moved one place toward either end, or replaced by a parallel word, with the choice made on every rising clock edge by a two-bit operation code. Each shift direction has its own serial entry pin, so a chain of these registers can pass data in both directions without external steering logic. The full register word is always visible on the parallel output.

An active-low clear empties the register at once, independent of the clock, and keeps it empty for as long as it is held low. The width is set by the `WIDTH` parameter (default 4, at least 2). The operation code works as the block's state-transition selector: `OP_KEEP` (00) loops the stored word back on itself, `OP_RIGHT` (01) moves it toward bit 0, `OP_LEFT` (10) moves it toward the top bit, and `OP_LOAD` (11) replaces it. The clear transition leaves any of these to the all-zero word.

Top module: `ushift_reg`

## Requirements
- R1: With `mode` = 2'b00 (keep), a rising clock edge leaves `par_out` unchanged.
- R2: With `mode` = 2'b01 (shift right), a rising edge moves every bit one place toward bit 0; bit WIDTH-1 takes `ser_r` and the old bit 0 is discarded.
- R3: With `mode` = 2'b10 (shift left), a rising edge moves every bit one place toward bit WIDTH-1; bit 0 takes `ser_l` and the old top bit is discarded.
- R4: With `mode` = 2'b11 (load), a rising edge copies `par_in` into the register.
- R5: Driving `clr_n` low sets every bit of `par_out` to 0 without waiting for a clock edge, including when it is pulsed between two edges.
- R6: While `clr_n` stays low, clock edges change nothing whatever the mode and data inputs; the register stays at zero.
- R7: `par_out` shows the stored word directly: the result of an edge is visible right after that edge, with no extra delay stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation code: 00 keep, 01 shift right, 10 shift left, 11 load |
| ser_r | input | 1 | Serial bit entering the top bit on a right shift |
| ser_l | input | 1 | Serial bit entering bit 0 on a left shift |
| par_in | input | WIDTH | Word copied in on a load |
| par_out | output | WIDTH | Current register contents |

## Verification
The hardest situation to reach is a clear that arrives and leaves between two clock edges while a non-keep operation is already set up, because the next edge must then act on the all-zero word rather than on the contents before the pulse. The stimulus sets a random mode and data at the falling edge, drops `clr_n` a quarter period later, checks the output mid-cycle, releases it before the rising edge and predicts the following result from zero. Held clears across several edges with random modes, and long random runs with independent serial bits, cover the remaining transitions.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        OP_KEEP  = 2'b00,
        OP_RIGHT = 2'b01,
        OP_LEFT  = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

endpackage

// File: rtl/ushift_cell.sv
module ushift_cell
    import ushift_pkg::*;
(
    input  op_e  op,
    input  logic own_bit,
    input  logic upper_bit,
    input  logic lower_bit,
    input  logic load_bit,
    output logic next_bit
);

    always_comb begin
        unique case (op)
            OP_KEEP:  next_bit = own_bit;
            OP_RIGHT: next_bit = upper_bit;
            OP_LEFT:  next_bit = lower_bit;
            OP_LOAD:  next_bit = load_bit;
            default:  next_bit = own_bit;
        endcase
    end

endmodule

// File: rtl/ushift_store.sv
module ushift_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out
);

    localparam int TOP = WIDTH - 1;

    if (WIDTH < 2) begin : g_width_guard
        $error("ushift_reg: WIDTH must be at least 2");
    end

    op_e              op;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt_q;
    logic [WIDTH-1:0] from_upper;
    logic [WIDTH-1:0] from_lower;

    assign op         = op_e'(mode);
    assign from_upper = {ser_r, cur_q[TOP:1]};
    assign from_lower = {cur_q[TOP-1:0], ser_l};

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        ushift_cell u_cell (
            .op        (op),
            .own_bit   (cur_q[i]),
            .upper_bit (from_upper[i]),
            .lower_bit (from_lower[i]),
            .load_bit  (par_in[i]),
            .next_bit  (nxt_q[i])
        );
    end

    ushift_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (nxt_q),
        .q     (cur_q)
    );

    assign par_out = cur_q;

endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode,
    input logic             ser_r,
    input logic             ser_l,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out
);

    // Set by any clear between edges, dropped at the next edge; its sampled
    // value at an edge tells whether a clear struck during the cycle before.
    logic clr_hit;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            clr_hit <= 1'b1;
        end else begin
            clr_hit <= 1'b0;
        end
    end

    assert_keep_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> (clr_hit || $stable(par_out)));

    assert_right_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (clr_hit ||
            par_out == {$past(ser_r), $past(par_out[WIDTH-1:1])}));

    assert_left_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (clr_hit ||
            par_out == {$past(par_out[WIDTH-2:0]), $past(ser_l)}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (clr_hit || par_out == $past(par_in)));

    assert_clear_R5: assert property (@(posedge clk)
        (!clr_n) |-> (par_out == '0));

    assert_clear_held_R6: assert property (@(posedge clk)
        (!clr_n && $past(!clr_n)) |-> $stable(par_out));

endmodule

bind ushift_reg ushift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .mode    (mode),
    .ser_r   (ser_r),
    .ser_l   (ser_l),
    .par_in  (par_in),
    .par_out (par_out)
);

// File: tb/test_ushift_reg.sv
module test_ushift_reg;

    localparam int W      = 4;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         ser_r = 1'b0;
    logic         ser_l = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_out;

    int           n_checks = 0;
    int           n_fail   = 0;
    bit           finished = 1'b0;
    logic [W-1:0] model    = '0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    ushift_reg #(.WIDTH(W)) i_ushift_reg (
        .clk     (clk),
        .clr_n   (clr_n),
        .mode    (mode),
        .ser_r   (ser_r),
        .ser_l   (ser_l),
        .par_in  (par_in),
        .par_out (par_out)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: par_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] predict(input logic [1:0] m, input logic [W-1:0] q,
                                             input logic sr, input logic sl,
                                             input logic [W-1:0] d);
        case (m)
            2'b00:   return q;
            2'b01:   return {sr, q[W-1:1]};
            2'b10:   return {q[W-2:0], sl};
            default: return d;
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4/R7";
        endcase
    endfunction

    // Monitor: compare every queued prediction just after the edge it belongs to.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(par_out, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Driver: set inputs at the falling edge and queue the result of the next rise.
    task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                        input logic [W-1:0] d);
        @(negedge clk);
        mode = m; ser_r = sr; ser_l = sl; par_in = d;
        model = predict(m, model, sr, sl, d);
        exp_q.push_back(model);
        tag_q.push_back(mode_tag(m));
    endtask

    task automatic rand_step();
        step(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), W'($urandom));
    endtask

    // Clear pulsed between edges with a live operation set up (R5).
    task automatic mid_clear();
        logic [1:0]   m;
        logic         sr;
        logic         sl;
        logic [W-1:0] d;
        @(negedge clk);
        m = 2'($urandom_range(1, 3)); sr = 1'($urandom); sl = 1'($urandom); d = W'($urandom);
        mode = m; ser_r = sr; ser_l = sl; par_in = d;
        #(PERIOD/4);
        clr_n = 1'b0;
        #1;
        check(par_out, '0, "R5");
        clr_n = 1'b1;
        model = predict(m, '0, sr, sl, d);
        exp_q.push_back(model);
        tag_q.push_back("R5");
    endtask

    // Clear held over several edges with random operations (R6).
    task automatic held_clear(input int edges);
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        check(par_out, '0, "R5");
        model = '0;
        for (int k = 0; k < edges; k++) begin
            @(negedge clk);
            mode = 2'($urandom_range(0, 3)); ser_r = 1'b1; ser_l = 1'b1; par_in = '1;
            exp_q.push_back('0);
            tag_q.push_back("R6");
        end
        @(negedge clk);
        clr_n = 1'b1;
        mode = 2'b00;
    endtask

    initial begin
        #(PERIOD/4);
        check(par_out, '0, "R5");
        #(PERIOD);
        @(negedge clk);
        clr_n = 1'b1;

        // Directed: load, keep, shifts with both serial values.
        step(2'b11, 1'b0, 1'b0, 4'b1010);
        step(2'b00, 1'b1, 1'b1, 4'b0101);
        step(2'b01, 1'b1, 1'b0, 4'b0000);
        step(2'b01, 1'b0, 1'b1, 4'b1111);
        step(2'b10, 1'b0, 1'b1, 4'b0000);
        step(2'b10, 1'b1, 1'b0, 4'b0000);
        for (int k = 0; k < W + 1; k++) step(2'b01, 1'b1, 1'b0, '0);
        for (int k = 0; k < W + 1; k++) step(2'b10, 1'b0, 1'b0, '1);
        step(2'b11, 1'b0, 1'b0, 4'b0110);

        held_clear(4);
        for (int k = 0; k < 400; k++) begin
            rand_step();
            if (k % 37 == 5)  mid_clear();
            if (k % 101 == 50) held_clear(3);
        end

        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule